// File: doc/BRIEF.md
# Remote Atomic Update Engine

The engine sits at the receive side of a fabric endpoint. It accepts whole update packets, each exactly one cache line wide, and applies the atomic updates packed inside them to a local memory through a plain synchronous memory port. A packet is split into equal slots. Each slot describes one update: an opcode, a target word address, a 64-bit operand and a flag asking for the old value back. Compare-and-swap needs a second value, so it takes two neighbouring slots.

Updates are applied one at a time. A packet's slots go in ascending order, and packets go in the order they are accepted. Every update owns the memory port for three cycles: read, compute, write. No other update can touch memory in that window, so each read-modify-write is atomic with respect to all the others. When an update asks for a fetch, the engine returns a one-cycle response carrying the pre-update word and the slot index. No per-update notification is generated. The only record of arrival is a free-running count of accepted packets.

Top module: `atomic_update_engine`

## Requirements
- R1: Reset state. After reset, `in_ready` is 1, `pkt_count` is 0, and `rsp_valid`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: Slot layout. The 1024-bit line holds eight 128-bit slots. Slot s occupies line bits [128*s+127 : 128*s]. Inside a slot:
  - bits [3:0] are the opcode;
  - bit 4 is the valid flag;
  - bit 5 is the fetch flag;
  - bits [47:8] are the word address;
  - bits [127:64] are the operand.
- R3: Opcode 0 stores old+operand, wrapping modulo 2^64. Opcode 1 stores old AND operand, opcode 2 stores old OR operand, and opcode 3 stores old XOR operand.
- R4: Opcode 4 is compare-and-swap. The compare value is the operand field of the next slot, whose other fields are ignored. The operand is written only when the old word equals the compare value; on a mismatch no write strobe is issued. A compare-and-swap placed in the last slot is skipped entirely.
- R5: When the fetch flag of an applied update is set, `rsp_valid` pulses for exactly one cycle. During that cycle, `rsp_data` holds the word as it was before the update and `rsp_idx` holds the slot index, which for compare-and-swap is its first slot.
- R6: Each applied update performs one read and, two cycles later, at most one write to the same address. The cycle between them has no memory access, and read and write never coincide.
- R7: All valid slots of a packet are applied in ascending slot order, with later updates seeing earlier results. A slot is skipped with no memory access and no response when any of the following holds:
  - its valid flag is clear;
  - its opcode is above 4;
  - it is the compare slot consumed by a compare-and-swap.
- R8: `in_ready` drops in the cycle after a packet is accepted and stays low until every update of that packet has completed. Packets are applied in acceptance order.
- R9: `pkt_count` increases by one for every accepted packet, including packets with no valid slot, and wraps at 2^CNT_W.
- R10: An applied update whose fetch flag is clear produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Engine can accept a packet |
| in_line | input | 1024 | Packet line (NSLOT*SLOT_W) |
| mem_rd_en | output | 1 | Memory read strobe; data is returned on the next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 40 | Word address for the read or write |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after `mem_rd_en` |
| rsp_valid | output | 1 | Fetch response strobe |
| rsp_idx | output | 3 | Slot index of the fetched update |
| rsp_data | output | 64 | Pre-update word |
| pkt_count | output | CNT_W | Accepted packet count |

## Verification
The arithmetic opcodes are each swept with all eight slots set and over six operand patterns: all ones, zero, the top bit alone, alternating bits, one, and nibble stripes. This separates carry handling from the bitwise functions and exposes any mix-up between opcodes. A packet whose eight additions all target one word shows whether slots are applied in order and whether each update sees the result of the previous one. Compare-and-swap is tried with a match, a mismatch, without fetch, and in the last slot; these separate the write gate from the slot pairing. A sweep of all sixteen opcode values, alongside invalid slots that carry live fields, and an empty packet confirm that skipped slots never reach memory while still advancing the packet count.

// File: rtl/ram_pkg.sv
package ram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } eng_state_e;

    localparam logic [3:0] OPC_ADD = 4'd0;
    localparam logic [3:0] OPC_AND = 4'd1;
    localparam logic [3:0] OPC_OR  = 4'd2;
    localparam logic [3:0] OPC_XOR = 4'd3;
    localparam logic [3:0] OPC_CAS = 4'd4;

    localparam int OPC_W     = 4;
    localparam int FLD_OPC   = 0;
    localparam int FLD_VALID = 4;
    localparam int FLD_FETCH = 5;
    localparam int FLD_ADDR  = 8;

endpackage

// File: rtl/ram_slot_dec.sv
module ram_slot_dec
    import ram_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 128,
    parameter int ADDR_W = 40,
    parameter int DATA_W = 64
) (
    input  logic [NSLOT*SLOT_W-1:0]   line,
    input  logic [$clog2(NSLOT)-1:0]  idx,
    output logic                      upd_ok,
    output logic [OPC_W-1:0]          opc,
    output logic                      fetch,
    output logic                      is_cas,
    output logic [ADDR_W-1:0]         addr,
    output logic [DATA_W-1:0]         operand,
    output logic [DATA_W-1:0]         cmp_val
);
    localparam int IDX_W   = $clog2(NSLOT);
    localparam int OPND_LO = SLOT_W - DATA_W;
    localparam int ADDR_HI = FLD_ADDR + ADDR_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

    logic [SLOT_W-1:0] slots [NSLOT];

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_unpack
            assign slots[g] = line[g*SLOT_W +: SLOT_W];
        end
    endgenerate

    logic [SLOT_W-1:0] cur;
    logic [SLOT_W-1:0] nxt;
    logic              dec_unused;

    assign cur = slots[idx];
    assign nxt = slots[idx + 1'b1];

    assign opc     = cur[FLD_OPC +: OPC_W];
    assign fetch   = cur[FLD_FETCH];
    assign addr    = cur[FLD_ADDR +: ADDR_W];
    assign operand = cur[OPND_LO +: DATA_W];
    assign cmp_val = nxt[OPND_LO +: DATA_W];
    assign is_cas  = (opc == OPC_CAS);

    // Updates need a supported opcode; a pair cannot start in the last slot.
    assign upd_ok = cur[FLD_VALID] && (opc <= OPC_CAS) && !(is_cas && (idx == LAST_IDX));

    assign dec_unused = ^{cur[FLD_FETCH+1 +: FLD_ADDR-FLD_FETCH-1],
                          cur[OPND_LO-1:ADDR_HI], nxt[OPND_LO-1:0]};

endmodule

// File: rtl/ram_alu.sv
module ram_alu
    import ram_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write
);
    always_comb begin
        new_val  = old_val;
        do_write = 1'b1;
        case (opc)
            OPC_ADD: new_val = old_val + operand;
            OPC_AND: new_val = old_val & operand;
            OPC_OR:  new_val = old_val | operand;
            OPC_XOR: new_val = old_val ^ operand;
            OPC_CAS: begin
                new_val  = operand;
                do_write = (old_val == cmp_val);
            end
            default: do_write = 1'b0;
        endcase
    end
endmodule

// File: rtl/ram_pkt_counter.sv
module ram_pkt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (count == $past(count) + 1'b1));
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

endmodule

// File: rtl/atomic_update_engine.sv
module atomic_update_engine
    import ram_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 128,
    parameter int ADDR_W = 40,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16,
    localparam int LINE_W = NSLOT * SLOT_W,
    localparam int IDX_W  = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_line,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  pkt_count
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);
    localparam logic [IDX_W:0]   SLOT_END = (IDX_W+1)'(NSLOT);

    typedef struct packed {
        eng_state_e        st;
        logic [LINE_W-1:0] line;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] old_val;
        logic [DATA_W-1:0] new_val;
        logic              wr;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              dec_ok;
    logic [OPC_W-1:0]  dec_opc;
    logic              dec_fetch;
    logic              dec_cas;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_opnd;
    logic [DATA_W-1:0] dec_cmp;
    logic [DATA_W-1:0] alu_new;
    logic              alu_wr;
    logic              accept;
    logic [IDX_W:0]    step;

    ram_slot_dec #(
        .NSLOT(NSLOT), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dec (
        .line(eng_q.line), .idx(eng_q.idx), .upd_ok(dec_ok), .opc(dec_opc),
        .fetch(dec_fetch), .is_cas(dec_cas), .addr(dec_addr),
        .operand(dec_opnd), .cmp_val(dec_cmp)
    );

    ram_alu #(.DATA_W(DATA_W)) u_alu (
        .opc(dec_opc), .old_val(mem_rdata), .operand(dec_opnd),
        .cmp_val(dec_cmp), .new_val(alu_new), .do_write(alu_wr)
    );

    ram_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(accept), .count(pkt_count)
    );

    assign in_ready  = (eng_q.st == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign mem_addr  = dec_addr;
    assign mem_wdata = eng_q.new_val;
    assign rsp_data  = eng_q.old_val;
    assign rsp_idx   = eng_q.idx;
    assign step      = {1'b0, eng_q.idx} + (dec_cas ? (IDX_W+1)'(2) : (IDX_W+1)'(1));

    always_comb begin
        eng_d     = eng_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        rsp_valid = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (accept) begin
                    eng_d.line = in_line;
                    eng_d.idx  = '0;
                    eng_d.st   = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (dec_ok) begin
                    mem_rd_en = 1'b1;
                    eng_d.st  = ST_EXEC;
                end else if (eng_q.idx == LAST_IDX) begin
                    eng_d.st  = ST_IDLE;
                end else begin
                    eng_d.idx = eng_q.idx + 1'b1;
                end
            end
            ST_EXEC: begin
                eng_d.old_val = mem_rdata;
                eng_d.new_val = alu_new;
                eng_d.wr      = alu_wr;
                eng_d.st      = ST_WRITE;
            end
            ST_WRITE: begin
                mem_wr_en = eng_q.wr;
                rsp_valid = dec_fetch;
                if (step >= SLOT_END) begin
                    eng_d.st  = ST_IDLE;
                end else begin
                    eng_d.idx = step[IDX_W-1:0];
                    eng_d.st  = ST_SCAN;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.st      <= ST_IDLE;
            eng_q.line    <= '0;
            eng_q.idx     <= '0;
            eng_q.old_val <= '0;
            eng_q.new_val <= '0;
            eng_q.wr      <= 1'b0;
        end else begin
            eng_q <= eng_d;
        end
    end

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en, 2) && ($past(mem_addr, 2) == mem_addr)));
    a_r6_quiet_middle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !(mem_rd_en || mem_wr_en));
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    a_r5_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_rd_en, 2));
    a_r8_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !(mem_wr_en || rsp_valid));

endmodule

// File: tb/tb_atomic_update_engine.sv
module tb_atomic_update_engine;
    localparam int NSLOT = 8, SLOT_W = 128, ADDR_W = 40, DATA_W = 64, CNT_W = 4;
    localparam int LINE_W = NSLOT * SLOT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [LINE_W-1:0] in_line = '0;
    logic              mem_rd_en, mem_wr_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              rsp_valid;
    logic [2:0]        rsp_idx;
    logic [DATA_W-1:0] rsp_data;
    logic [CNT_W-1:0]  pkt_count;

    always #2 clk = ~clk;

    atomic_update_engine #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
                           .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
        .pkt_count(pkt_count)
    );

    function automatic logic [63:0] initv(input int i);
        return (64'h0123_4567_89AB_CDEF * 64'(i + 1)) ^ (64'(i) << 7);
    endfunction

    // Behavioural memory, preloaded while reset is held
    logic [63:0] mem [64];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= initv(i);
            mem_rdata <= '0;
        end else begin
            if (mem_wr_en) mem[mem_addr[5:0]] <= mem_wdata;
            if (mem_rd_en) mem_rdata <= mem[mem_addr[5:0]];
        end
    end

    int checks = 0, errors = 0;
    logic [63:0] model [64];
    logic [63:0] exp_data [1024];
    int          exp_idx  [1024];
    int          exp_n = 0;
    logic [63:0] got_data [1024];
    int          got_idx  [1024];
    int          got_n = 0;
    int          rd_total = 0, wr_total = 0, seq_bad = 0, pkt_n = 0;
    logic        rd1 = 0, rd2 = 0;
    logic [39:0] a1 = '0, a2 = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && got_n < 1024) begin
                got_data[got_n] = rsp_data;
                got_idx[got_n]  = int'(rsp_idx);
                got_n++;
            end
            if (mem_rd_en) rd_total++;
            if (mem_wr_en) begin
                wr_total++;
                if (!(rd2 && a2 == mem_addr && !rd1)) seq_bad++;
            end
            if (mem_rd_en && mem_wr_en) seq_bad++;
            rd2 = rd1; a2 = a1; rd1 = mem_rd_en; a1 = mem_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [127:0] mk(input logic [3:0] op, input bit v, input bit f,
                                        input logic [39:0] a, input logic [63:0] opd);
        return {opd, 16'h0, a, 2'b00, f, v, op};
    endfunction

    // Requirement-level model: applies a line to the model memory
    task automatic model_apply(input logic [LINE_W-1:0] ln, output int nrd, output int nwr);
        int i = 0;
        nrd = 0; nwr = 0;
        while (i < 8) begin
            logic [127:0] s = ln[i*128 +: 128];
            logic [3:0]   op = s[3:0];
            logic [5:0]   a = s[13:8];
            logic [63:0]  opd = s[127:64];
            logic [63:0]  old, nv;
            bit           w;
            if (!s[4] || op > 4 || (op == 4 && i == 7)) begin
                i++;
            end else begin
                old = model[a]; nrd++; w = 1; nv = old;
                case (op)
                    4'd0: nv = old + opd;
                    4'd1: nv = old & opd;
                    4'd2: nv = old | opd;
                    4'd3: nv = old ^ opd;
                    default: begin
                        nv = opd;
                        w = (old == ln[(i+1)*128+64 +: 64]);
                    end
                endcase
                if (w) begin model[a] = nv; nwr++; end
                if (s[5]) begin exp_data[exp_n] = old; exp_idx[exp_n] = i; exp_n++; end
                i += (op == 4) ? 2 : 1;
            end
        end
    endtask

    task automatic send(input logic [LINE_W-1:0] ln, input string tag);
        int nrd, nwr, rd0, wr0, e0, g0;
        while (!in_ready) @(negedge clk);
        rd0 = rd_total; wr0 = wr_total; e0 = exp_n; g0 = got_n;
        model_apply(ln, nrd, nwr);
        in_valid = 1'b1; in_line = ln;
        @(negedge clk);
        in_valid = 1'b0;
        pkt_n++;
        chk(!in_ready, "R8 ready low after accept", 64'(in_ready), 0);
        while (!in_ready) @(negedge clk);
        for (int k = 0; k < 64; k++)
            chk(mem[k] == model[k], {"R3/R4/R7 memory ", tag}, mem[k], model[k]);
        chk(rd_total - rd0 == nrd, {"R7 read count ", tag}, 64'(rd_total - rd0), 64'(nrd));
        chk(wr_total - wr0 == nwr, {"R4/R6 write count ", tag}, 64'(wr_total - wr0), 64'(nwr));
        chk(got_n - g0 == exp_n - e0, {"R5/R10 response count ", tag}, 64'(got_n - g0), 64'(exp_n - e0));
        for (int k = 0; k < exp_n - e0; k++) begin
            if (g0 + k < got_n) begin
                chk(got_data[g0+k] == exp_data[e0+k], {"R5 fetch data ", tag}, got_data[g0+k], exp_data[e0+k]);
                chk(got_idx[g0+k] == exp_idx[e0+k], {"R5 fetch index ", tag}, 64'(got_idx[g0+k]), 64'(exp_idx[e0+k]));
            end
        end
        chk(pkt_count == CNT_W'(pkt_n), {"R9 packet count ", tag}, 64'(pkt_count), 64'(pkt_n % 16));
    endtask

    function automatic logic [63:0] pat(input int p, input int s);
        logic [63:0] b;
        case (p)
            0: b = '1;
            1: b = '0;
            2: b = 64'h8000_0000_0000_0000;
            3: b = 64'hAAAA_AAAA_AAAA_AAAA;
            4: b = 64'h1;
            default: b = 64'h0F0F_F0F0_0F0F_F0F0;
        endcase
        return (s == 0) ? b : ((b << s) | (b >> (64 - s)));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [LINE_W-1:0] ln;
        for (int i = 0; i < 64; i++) model[i] = initv(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 1);
        chk(pkt_count == '0, "R1 pkt_count", 64'(pkt_count), 0);
        chk(!rsp_valid && !mem_rd_en && !mem_wr_en, "R1 quiet outputs",
            64'({rsp_valid, mem_rd_en, mem_wr_en}), 0);

        // R2/R3: each arithmetic opcode over operand patterns, all slots set
        for (int op = 0; op < 4; op++)
            for (int p = 0; p < 6; p++) begin
                ln = '0;
                for (int s = 0; s < 8; s++)
                    ln[s*128 +: 128] = mk(4'(op), 1'b1, s[0], 40'((p*8 + s + op) % 64), pat(p, s));
                send(ln, "R3 opcode sweep");
            end

        // R7: chain of additions on one word, every one fetched
        ln = '0;
        for (int s = 0; s < 8; s++) ln[s*128 +: 128] = mk(4'd0, 1'b1, 1'b1, 40'd5, 64'(s + 1) << 60);
        send(ln, "R7 same-address chain");

        // R4: CAS match with fetch, mismatch with fetch, match without fetch, CAS in last slot
        ln = '0;
        ln[0*128 +: 128] = mk(4'd4, 1'b1, 1'b1, 40'd10, 64'hDEAD_BEEF_0000_0001);
        ln[1*128 +: 128] = mk(4'd9, 1'b1, 1'b1, 40'd11, model[10]);
        ln[2*128 +: 128] = mk(4'd4, 1'b1, 1'b1, 40'd12, 64'h1111);
        ln[3*128 +: 128] = mk(4'd0, 1'b0, 1'b0, 40'd0, ~model[12]);
        ln[4*128 +: 128] = mk(4'd4, 1'b1, 1'b0, 40'd13, 64'h2222);
        ln[5*128 +: 128] = mk(4'd2, 1'b1, 1'b1, 40'd13, model[13]);
        ln[6*128 +: 128] = mk(4'd3, 1'b1, 1'b1, 40'd13, 64'hFF);
        ln[7*128 +: 128] = mk(4'd4, 1'b1, 1'b1, 40'd14, 64'h3333);
        send(ln, "R4 compare-and-swap");

        // R4: CAS against the value written by an earlier slot of the same packet
        ln = '0;
        ln[0*128 +: 128] = mk(4'd3, 1'b1, 1'b0, 40'd20, 64'h55);
        ln[1*128 +: 128] = mk(4'd4, 1'b1, 1'b1, 40'd20, 64'h77);
        ln[2*128 +: 128] = mk(4'd0, 1'b0, 1'b0, 40'd0, model[20] ^ 64'h55);
        send(ln, "R4 CAS after update");

        // R7/R10: every opcode value, surrounded by invalid slots with live fields
        for (int op = 0; op < 16; op++) begin
            ln = '0;
            for (int s = 0; s < 8; s++)
                ln[s*128 +: 128] = mk(4'd0, 1'b0, 1'b1, 40'(40 + s), 64'hFFFF);
            ln[(op % 6)*128 +: 128] = mk(4'(op), 1'b1, op[0], 40'(30 + op % 8), pat(op % 6, op));
            send(ln, "R7 opcode value sweep");
        end

        // R9: empty packet still counts
        send('0, "R9 empty packet");

        chk(seq_bad == 0, "R6 read-exec-write sequence", 64'(seq_bad), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule